// File: doc/BRIEF.md
# Command Ring Walker for an Interrupt Translation Unit

This block drains a circular queue of 32-byte commands kept in system memory. Software fills slots in the ring and then writes the write-pointer register. If the unit is enabled and the new write index differs from the read index, the walker fetches the first 64-bit doubleword of the slot under the read pointer. It decodes the command code from the low byte of that doubleword.

Three codes carry mapping work: synchronise (0x05), device map (0x08) and collection map (0x09). For these, the walker hands the doubleword to an external command executor with a start pulse. It then waits for a done response, which may carry an error. Every other code is retired at once as a no-op. After each good command the read index steps forward and wraps at the ring depth. The walk ends when the read index reaches the write index that was latched at launch.

A failed memory read, or an executor error, stops the walk on the failing slot. The read pointer is not advanced, and a stall flag is raised in the read register.

Top module: `cmdq_walker`

## Requirements
- R1: After reset the enable bit, both pointer registers, `busy`, `bad_ptr`, `mem_req` and `exe_start` are all zero.
- R2: A write of the low 32-bit half (`reg_sel`=1) or of the full 64 bits (`reg_sel`=3) of the write pointer launches a walk when enable (`reg_sel`=0, bit 0) is set and the new index in bits [19:5] differs from the read index. In the cycle after the write edge, `busy` and `mem_req` are high and `mem_addr` equals `q_base` + read index × 32.
- R3: A write of the upper half alone (`reg_sel`=2) never launches a walk. Neither does a write while enable is clear, or a write whose index equals the read index. `busy` and `mem_req` stay low in each case.
- R4: A launching write whose index is not below `DEPTH` processes no command. It raises `bad_ptr` for exactly the one cycle after the write edge. The pointer register still takes the written value.
- R5: The command code is bits [7:0] of the fetched doubleword. Codes 0x05, 0x08 and 0x09 produce a one-cycle `exe_start`, with `exe_code` and `exe_dw0` equal to the fetched code and doubleword.
- R6: Any other code, known or unknown, is retired without `exe_start`, and the walk moves to the next slot.
- R7: After each successful command the read index in bits [19:5] of `rptr_q` becomes (index+1) mod `DEPTH`. `busy` falls when it reaches the latched write index.
- R8: A memory response with `mem_rerr` set halts the walk. The read index stays on the failing slot, `rptr_q` bit 0 (stalled) is set, `busy` falls, and no `exe_start` is issued for that slot.
- R9: An executor response with `exe_err` set halts the walk in the same way: the index stays put, the stalled bit is set and `busy` falls.
- R10: Writes to the write pointer while `busy` is high update the register only. The running walk still stops at the index latched at launch, and no new walk starts once it ends.
- R11: A `reg_sel`=4 write while idle loads the read index from bits [19:5] and clears the stalled bit. A later launch fetches from that index. Each launch clears the stalled bit.
- R12: At most one memory read is outstanding. `mem_req` is a single-cycle pulse, and the next request follows only after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 control, 1 write-pointer low half, 2 write-pointer high half, 3 write-pointer full, 4 read pointer |
| reg_wdata | input | 64 | Register write data |
| q_base | input | ADDR_W | Byte address of ring slot 0 |
| en | output | 1 | Enable bit |
| wptr_q | output | 64 | Write-pointer register |
| rptr_q | output | 64 | Read-pointer register (bit 0 stalled, index in [19:5]) |
| busy | output | 1 | Walk in progress |
| bad_ptr | output | 1 | One-cycle pulse on an out-of-range launch |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 64 | Memory response data, little-endian doubleword |
| mem_rerr | input | 1 | Memory response error |
| exe_start | output | 1 | Executor start pulse |
| exe_code | output | 8 | Command code for the executor |
| exe_dw0 | output | 64 | First doubleword for the executor |
| exe_done | input | 1 | Executor completion |
| exe_err | input | 1 | Executor error with completion |

## Verification
A launching write is registered on one edge. `busy`, `mem_req` and the fetch address are due in the very next cycle, and `bad_ptr` in that cycle only. The bench samples them at the falling edge right after the write. Each memory response is taken on the next rising edge. A dispatched code shows `exe_start` one cycle after that, and the read index moves one cycle after the command retires. The bench therefore checks pointers, stall flags and the logs of fetches and executor starts only once `busy` has fallen. The "no launch" cases are held and watched for several cycles.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    // Bit position of the ring index inside the pointer registers
    localparam int PTR_LSB = 5;
    // Log2 of the slot size in bytes (32-byte slots)
    localparam int SLOT_SHIFT = 5;

    typedef enum logic [7:0] {
        OP_INT     = 8'h03,
        OP_CLEAR   = 8'h04,
        OP_SYNC    = 8'h05,
        OP_MAPDEV  = 8'h08,
        OP_MAPCOLL = 8'h09,
        OP_MAPTI   = 8'h0A,
        OP_MAPI    = 8'h0B,
        OP_DISCARD = 8'h0F
    } cmd_op_e;

    typedef enum logic [2:0] {
        RS_CTRL      = 3'd0,
        RS_WPTR_LO   = 3'd1,
        RS_WPTR_HI   = 3'd2,
        RS_WPTR_FULL = 3'd3,
        RS_RPTR      = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_MEM,
        ST_DISPATCH,
        ST_WAIT_EXE,
        ST_ADVANCE
    } walk_state_e;

    typedef struct packed {
        logic [63:0] dw0;
        logic [7:0]  code;
        logic        dispatch;
    } decoded_t;

    // True for the codes that need the executor
    function automatic logic needs_exec(logic [7:0] code);
        return (code == OP_SYNC) || (code == OP_MAPDEV) || (code == OP_MAPCOLL);
    endfunction

    // Next slot of a ring of the given depth
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/cqp_regs.sv
module cqp_regs
    import cqp_pkg::*;
#(
    parameter int IDX_W = 15,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [63:0]      reg_wdata,
    input  logic             busy,
    input  logic             adv,
    input  logic             stall_set,
    output logic             en,
    output logic [63:0]      wptr_q,
    output logic [63:0]      rptr_q,
    output logic             launch,
    output logic [IDX_W-1:0] launch_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             bad_ptr
);
    localparam logic [63:0] IDX_MASK = ((64'd1 << IDX_W) - 64'd1) << PTR_LSB;

    logic [63:0]      wptr_next;
    logic             wptr_we;
    logic             lo_or_full;
    logic [IDX_W-1:0] new_idx;
    logic             want_launch;
    logic             in_range;
    logic [IDX_W-1:0] rd_next;

    always_comb begin
        wptr_next = wptr_q;
        wptr_we   = 1'b0;
        if (reg_wr) begin
            unique case (reg_sel_e'(reg_sel))
                RS_WPTR_LO: begin
                    wptr_next = {wptr_q[63:32], reg_wdata[31:0]};
                    wptr_we   = 1'b1;
                end
                RS_WPTR_HI: begin
                    wptr_next = {reg_wdata[31:0], wptr_q[31:0]};
                    wptr_we   = 1'b1;
                end
                RS_WPTR_FULL: begin
                    wptr_next = reg_wdata;
                    wptr_we   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign lo_or_full  = reg_wr && ((reg_sel == RS_WPTR_LO) || (reg_sel == RS_WPTR_FULL));
    assign new_idx     = wptr_next[PTR_LSB +: IDX_W];
    assign rd_idx      = rptr_q[PTR_LSB +: IDX_W];
    assign in_range    = 32'(new_idx) < 32'(DEPTH);
    assign want_launch = lo_or_full && en && !busy && (new_idx != rd_idx);
    assign launch      = want_launch && in_range;
    assign launch_idx  = new_idx;
    assign rd_next     = IDX_W'(ring_next(32'(rd_idx), 32'(DEPTH)));

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            wptr_q  <= '0;
            rptr_q  <= '0;
            bad_ptr <= 1'b0;
        end else begin
            bad_ptr <= want_launch && !in_range;
            if (reg_wr && (reg_sel == RS_CTRL)) begin
                en <= reg_wdata[0];
            end
            if (wptr_we) begin
                wptr_q <= wptr_next;
            end
            if (reg_wr && (reg_sel == RS_RPTR) && !busy) begin
                rptr_q <= reg_wdata & IDX_MASK;
            end else begin
                if (launch) begin
                    rptr_q[0] <= 1'b0;
                end
                if (stall_set) begin
                    rptr_q[0] <= 1'b1;
                end
                if (adv) begin
                    rptr_q[PTR_LSB +: IDX_W] <= rd_next;
                end
            end
        end
    end

endmodule

// File: rtl/cqp_decode.sv
module cqp_decode
    import cqp_pkg::*;
(
    input  logic [63:0] dw,
    output decoded_t    dec
);
    always_comb begin
        dec.dw0      = dw;
        dec.code     = dw[7:0];
        dec.dispatch = needs_exec(dw[7:0]);
    end
endmodule

// File: rtl/cqp_walk_fsm.sv
module cqp_walk_fsm
    import cqp_pkg::*;
#(
    parameter int IDX_W  = 15,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [IDX_W-1:0]  launch_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] q_base,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  decoded_t          dec,
    input  logic              exe_done,
    input  logic              exe_err,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              exe_start,
    output logic [7:0]        exe_code,
    output logic [63:0]       exe_dw0,
    output logic              adv,
    output logic              stall_set
);
    walk_state_e      state;
    logic [IDX_W-1:0] end_idx;
    logic [IDX_W-1:0] rd_next;

    assign rd_next   = IDX_W'(ring_next(32'(rd_idx), 32'(DEPTH)));
    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_FETCH);
    assign mem_addr  = q_base + (ADDR_W'(rd_idx) << SLOT_SHIFT);
    assign exe_start = (state == ST_DISPATCH);
    assign adv       = (state == ST_ADVANCE);
    assign stall_set = ((state == ST_WAIT_MEM) && mem_rvalid && mem_rerr) ||
                       ((state == ST_WAIT_EXE) && exe_done && exe_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            end_idx  <= '0;
            exe_code <= '0;
            exe_dw0  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        end_idx <= launch_idx;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_WAIT_MEM;
                ST_WAIT_MEM: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            state <= ST_IDLE;
                        end else begin
                            exe_code <= dec.code;
                            exe_dw0  <= dec.dw0;
                            state    <= dec.dispatch ? ST_DISPATCH : ST_ADVANCE;
                        end
                    end
                end
                ST_DISPATCH: state <= ST_WAIT_EXE;
                ST_WAIT_EXE: begin
                    if (exe_done) begin
                        state <= exe_err ? ST_IDLE : ST_ADVANCE;
                    end
                end
                ST_ADVANCE: state <= (rd_next == end_idx) ? ST_IDLE : ST_FETCH;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdq_walker.sv
module cmdq_walker
    import cqp_pkg::*;
#(
    parameter int IDX_W  = 15,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    input  logic [ADDR_W-1:0] q_base,
    output logic              en,
    output logic [63:0]       wptr_q,
    output logic [63:0]       rptr_q,
    output logic              busy,
    output logic              bad_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              exe_start,
    output logic [7:0]        exe_code,
    output logic [63:0]       exe_dw0,
    input  logic              exe_done,
    input  logic              exe_err
);
    logic             launch;
    logic [IDX_W-1:0] launch_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             adv;
    logic             stall_set;
    decoded_t         dec;

    cqp_regs #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .adv        (adv),
        .stall_set  (stall_set),
        .en         (en),
        .wptr_q     (wptr_q),
        .rptr_q     (rptr_q),
        .launch     (launch),
        .launch_idx (launch_idx),
        .rd_idx     (rd_idx),
        .bad_ptr    (bad_ptr)
    );

    cqp_decode u_dec (
        .dw  (mem_rdata),
        .dec (dec)
    );

    cqp_walk_fsm #(.IDX_W(IDX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_idx (launch_idx),
        .rd_idx     (rd_idx),
        .q_base     (q_base),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .dec        (dec),
        .exe_done   (exe_done),
        .exe_err    (exe_err),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .exe_start  (exe_start),
        .exe_code   (exe_code),
        .exe_dw0    (exe_dw0),
        .adv        (adv),
        .stall_set  (stall_set)
    );

endmodule

// File: rtl/cqp_chk.sv
module cqp_chk #(
    parameter int IDX_W = 15,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             bad_ptr,
    input logic             mem_req,
    input logic             exe_start,
    input logic [7:0]       exe_code,
    input logic [IDX_W-1:0] rd_idx
);
    p_req_in_walk_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_bad_ptr_idle_r4: assert property (@(posedge clk) disable iff (rst)
        bad_ptr |-> !busy);

    p_start_mapping_r5: assert property (@(posedge clk) disable iff (rst)
        exe_start |-> (exe_code == 8'h05 || exe_code == 8'h08 || exe_code == 8'h09));

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        exe_start |=> !exe_start);

    p_rd_step_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$stable(rd_idx)) |->
        (rd_idx == (($past(rd_idx) == IDX_W'(DEPTH - 1)) ? '0 : $past(rd_idx) + 1'b1)));

    p_req_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
endmodule

bind cmdq_walker cqp_chk #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .bad_ptr   (bad_ptr),
    .mem_req   (mem_req),
    .exe_start (exe_start),
    .exe_code  (exe_code),
    .rd_idx    (rptr_q[cqp_pkg::PTR_LSB +: IDX_W])
);

// File: tb/cmdq_walker_tb.sv
module cmdq_walker_tb;
    localparam int IDX_W  = 15;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 48;
    localparam logic [ADDR_W-1:0] BASE = 48'h0000_8000_1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_sel = '0;
    logic [63:0]       reg_wdata = '0;
    logic              en;
    logic [63:0]       wptr_q;
    logic [63:0]       rptr_q;
    logic              busy;
    logic              bad_ptr;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [63:0]       mem_rdata = '0;
    logic              mem_rerr = 1'b0;
    logic              exe_start;
    logic [7:0]        exe_code;
    logic [63:0]       exe_dw0;
    logic              exe_done = 1'b0;
    logic              exe_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int mem_lat = 2;
    int exe_lat = 1;
    int mem_err_idx = -1;
    logic [7:0] fail_code = 8'h00;

    int fetch_n = 0;
    int fetch_idx [0:63];
    int exe_n = 0;
    logic [7:0]  exe_log_code [0:63];
    logic [63:0] exe_log_dw [0:63];

    always #5 clk = ~clk;

    cmdq_walker #(.IDX_W(IDX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .q_base(BASE), .en(en), .wptr_q(wptr_q), .rptr_q(rptr_q), .busy(busy),
        .bad_ptr(bad_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .exe_start(exe_start), .exe_code(exe_code), .exe_dw0(exe_dw0),
        .exe_done(exe_done), .exe_err(exe_err)
    );

    function automatic logic [7:0] slot_code(int i);
        case (i % 8)
            0: return 8'h05;
            1: return 8'h03;
            2: return 8'h08;
            3: return 8'h09;
            4: return 8'h77;
            5: return 8'h04;
            6: return 8'h0B;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic logic [63:0] slot_dw(int i);
        return {16'hC0DE, 8'(i), 32'h1234_5678, slot_code(i)};
    endfunction

    function automatic bit is_map(logic [7:0] c);
        return (c == 8'h05) || (c == 8'h08) || (c == 8'h09);
    endfunction

    // Memory model: one response per request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                int idx;
                idx = int'((mem_addr - BASE) >> 5);
                if (fetch_n < 64) fetch_idx[fetch_n] = idx;
                fetch_n++;
                repeat (mem_lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = slot_dw(idx);
                mem_rerr   = (idx == mem_err_idx);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rerr   = 1'b0;
            end
        end
    end

    // Executor model
    initial begin
        forever begin
            @(negedge clk);
            if (exe_start) begin
                logic [7:0] c;
                c = exe_code;
                if (exe_n < 64) begin
                    exe_log_code[exe_n] = exe_code;
                    exe_log_dw[exe_n]   = exe_dw0;
                end
                exe_n++;
                repeat (exe_lat) @(negedge clk);
                exe_done = 1'b1;
                exe_err  = (c == fail_code);
                @(negedge clk);
                exe_done = 1'b0;
                exe_err  = 1'b0;
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [63:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    endtask

    task automatic clear_logs();
        fetch_n = 0;
        exe_n = 0;
    endtask

    function automatic logic [63:0] ix(int i);
        return 64'(i) << 5;
    endfunction

    // Expect fetches and executor starts for slots from..(to-1) around the ring
    task automatic check_walk(string tag, int from, int to);
        int n = 0;
        int m = 0;
        int i = from;
        while (i != to) begin
            if (n < fetch_n) chk({tag, " fetch slot"}, 64'(fetch_idx[n]), 64'(i));
            if (is_map(slot_code(i))) begin
                if (m < exe_n) begin
                    chk({tag, " exe code"}, 64'(exe_log_code[m]), 64'(slot_code(i)));
                    chk({tag, " exe dw0"}, exe_log_dw[m], slot_dw(i));
                end
                m++;
            end
            n++;
            i = (i + 1) % DEPTH;
        end
        chk({tag, " fetch count"}, 64'(fetch_n), 64'(n));
        chk({tag, " exe count"}, 64'(exe_n), 64'(m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 en", 64'(en), 0);
        chk("R1 wptr", wptr_q, 0);
        chk("R1 rptr", rptr_q, 0);
        chk("R1 busy", 64'(busy), 0);
        chk("R1 bad_ptr", 64'(bad_ptr), 0);
        chk("R1 mem_req", 64'(mem_req), 0);
        chk("R1 exe_start", 64'(exe_start), 0);

        // R2/R5/R6/R7: full write, slots 0..4
        wr(3'd0, 64'd1);
        clear_logs();
        wr(3'd3, ix(5));
        chk("R2 busy next cycle", 64'(busy), 1);
        chk("R2 mem_req next cycle", 64'(mem_req), 1);
        chk("R2 mem_addr", 64'(mem_addr), 64'(BASE));
        wait_idle();
        check_walk("R5 R6 first walk", 0, 5);
        chk("R7 rd index", rptr_q, ix(5));

        // R7 wrap via low-half write: 5..15,0..2
        clear_logs();
        wr(3'd1, ix(3));
        chk("R2 low-half launch", 64'(busy), 1);
        chk("R2 addr slot5", 64'(mem_addr), 64'(BASE) + 64'(5 * 32));
        wait_idle();
        check_walk("R7 wrap walk", 5, 3);
        chk("R7 wrapped rd", rptr_q, ix(3));

        // R3 no-launch cases
        clear_logs();
        wr(3'd0, 64'd0);
        wr(3'd3, ix(7));
        chk("R3 disabled", 64'(busy), 0);
        wr(3'd0, 64'd1);
        wr(3'd2, 64'hFFFF_0000);
        chk("R3 high half", 64'(busy), 0);
        chk("R3 high half stored", wptr_q, 64'hFFFF_0000_0000_0000 | ix(7));
        wr(3'd1, ix(3));
        chk("R3 equal index", 64'(busy), 0);
        repeat (5) @(negedge clk);
        chk("R3 no fetch", 64'(fetch_n), 0);

        // R4 out of range
        wr(3'd3, ix(20));
        chk("R4 bad_ptr pulse", 64'(bad_ptr), 1);
        chk("R4 busy low", 64'(busy), 0);
        chk("R4 reg stored", wptr_q, ix(20));
        @(negedge clk);
        chk("R4 bad_ptr one cycle", 64'(bad_ptr), 0);
        repeat (4) @(negedge clk);
        chk("R4 no fetch", 64'(fetch_n), 0);
        chk("R4 rd unchanged", rptr_q, ix(3));

        // R8 memory error at slot 5
        clear_logs();
        mem_err_idx = 5;
        wr(3'd3, ix(8));
        wait_idle();
        chk("R8 fetches", 64'(fetch_n), 3);
        chk("R8 exe count", 64'(exe_n), 1);
        chk("R8 rd stalled", rptr_q, ix(5) | 64'd1);

        // R11 relaunch clears stall
        mem_err_idx = -1;
        clear_logs();
        wr(3'd3, ix(8));
        chk("R11 stall cleared at launch", 64'(rptr_q[0]), 0);
        wait_idle();
        check_walk("R11 resume walk", 5, 8);
        chk("R11 rd after resume", rptr_q, ix(8));

        // R9 executor error on code 0x08 (slot 10)
        fail_code = 8'h08;
        clear_logs();
        wr(3'd3, ix(13));
        wait_idle();
        chk("R9 fetches", 64'(fetch_n), 3);
        chk("R9 exe count", 64'(exe_n), 2);
        chk("R9 rd stalled", rptr_q, ix(10) | 64'd1);

        // R10 writes while busy
        fail_code = 8'h00;
        exe_lat = 6;
        clear_logs();
        wr(3'd3, ix(14));
        repeat (3) @(negedge clk);
        chk("R10 busy during walk", 64'(busy), 1);
        wr(3'd3, ix(2));
        chk("R10 reg updated", wptr_q, ix(2));
        wait_idle();
        check_walk("R10 latched end", 10, 14);
        chk("R10 rd", rptr_q, ix(14));
        repeat (10) @(negedge clk);
        chk("R10 no relaunch", 64'(busy), 0);
        chk("R10 no extra fetch", 64'(fetch_n), 4);

        // R11 software read-pointer load
        exe_lat = 1;
        wr(3'd4, ix(4) | 64'd1);
        chk("R11 rptr load", rptr_q, ix(4));
        chk("R11 no walk", 64'(busy), 0);
        clear_logs();
        wr(3'd1, ix(6));
        chk("R11 fetch from loaded", 64'(mem_addr), 64'(BASE) + 64'(4 * 32));
        wait_idle();
        check_walk("R11 walk", 4, 6);
        chk("R11 rd end", rptr_q, ix(6));

        // R12 each request answered before the next
        chk("R12 one request per slot", 64'(fetch_n), 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule